// File: doc/BRIEF.md
# Streaming Indirect Memory Window

This block gives a host a narrow register window onto a word-organised internal SRAM. The host loads a write pointer or a read pointer and then streams words through a write-data or a read-data register. Every data access moves its own pointer forward by one 32-bit word. The read and write pointers are independent, so a stream can be written at one place and read back from another without reloading.

A second indirect path reaches a small internal register file. It uses a control word that carries a byte offset, a byte count and a command, together with a data word. To write, the host first loads the data word and then issues a write command. To read, the host issues a read command and then fetches the data word. Read data for the SRAM path is prefetched, so back-to-back reads of the read-data register run with no stall.

Host requests use a valid/ready handshake. Every read gets exactly one response on a separate valid/ready channel, and writes get no response. A response that is not taken stalls all further requests. While it waits, the response holds its data.

Top module: `ind_mem_port`

## Requirements
- R1: After reset, both pointers, the shared control word and the shared data word read as 0, and no response is pending.
- R2: A write to the write-data register (offset 0x08) stores the data at word index `ptr[IW+1:2]` of the write pointer. It then adds one to that index modulo MEM_DEPTH and leaves pointer bits 31:IW+2 and 1:0 unchanged.
- R3: A read of the read-data register (offset 0x0C) returns the word at the read pointer's index. The read pointer then advances in the same way as in R2.
- R4: A write to the write-pointer register (0x00) or the read-pointer register (0x04) loads all 32 bits. A read of either register returns its current value.
- R5: Once the read pointer is set, consecutive read-data requests are accepted on every cycle while responses are taken.
- R6: After a write to the word the read pointer currently addresses, the next read-data access returns the new word.
- R7: A shared-control write (0x10) whose bits 29:28 equal 2 loads the shared data word (0x14) from entry `offset[15:0]/4`. Only the lowest (bits 25:24 + 1) bytes are kept, and the rest are zero. A read of 0x10 returns the last control word written.
- R8: A shared-control write whose bits 29:28 equal 3 writes the lowest (bits 25:24 + 1) bytes of the shared data word into the addressed entry. The other bytes of that entry are kept.
- R9: Commands 0 and 1 change neither the register file nor the shared data word. A read at an offset past the file loads 0, and a write at such an offset changes no entry.
- R10: Each read request yields one response. While `host_rsp_valid` is high and `host_rsp_ready` is low, the response data holds and `host_req_ready` stays low.
- R11: Unmapped offsets and the write-data register read as 0. Writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Request accepted on this edge |
| host_req_write | input | 1 | 1 = register write, 0 = register read |
| host_req_addr | input | 8 | Register byte offset |
| host_req_wdata | input | 32 | Write data |
| host_rsp_valid | output | 1 | Read response present |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_rdata | output | 32 | Read response data |

## Verification
A read response appears in the cycle after its request is accepted. Pointer and shared-word updates take effect at the accepting edge, so a read issued on the next request sees them. A write that hits the prefetched word costs one cycle, during which read-data requests are held off. The bench drives every request at a falling edge and tests `host_req_ready` shortly after. It then samples the response at the next falling edge, one edge after acceptance, and loops on ready so that these stall cycles never shift a comparison.

// File: rtl/ind_pkg.sv
package ind_pkg;
  localparam int REG_AW = 8;
  localparam int DW     = 32;

  typedef logic [REG_AW-1:0] reg_off_t;

  localparam reg_off_t OFF_WR_ADDR  = 8'h00;
  localparam reg_off_t OFF_RD_ADDR  = 8'h04;
  localparam reg_off_t OFF_WR_DATA  = 8'h08;
  localparam reg_off_t OFF_RD_DATA  = 8'h0C;
  localparam reg_off_t OFF_SHR_CTRL = 8'h10;
  localparam reg_off_t OFF_SHR_DATA = 8'h14;

  localparam int SHR_OFF_W   = 16;
  localparam int SHR_CNT_LSB = 24;
  localparam int SHR_CMD_LSB = 28;

  typedef enum logic [1:0] {
    SHR_NOP0 = 2'd0,
    SHR_NOP1 = 2'd1,
    SHR_RD   = 2'd2,
    SHR_WR   = 2'd3
  } shr_cmd_e;

  // byte lanes 0..cnt enabled
  function automatic logic [DW-1:0] byte_mask(input logic [1:0] cnt);
    logic [DW-1:0] m;
    for (int b = 0; b < DW / 8; b++) begin
      m[b*8 +: 8] = (b <= int'(cnt)) ? 8'hFF : 8'h00;
    end
    return m;
  endfunction
endpackage

// File: rtl/ind_ptr.sv
module ind_ptr #(
  parameter int MEM_DEPTH = 64,
  parameter int PW        = 32,
  localparam int IW       = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic [IW-1:0] nxt_idx
);
  logic [PW-1:0] nxt;

  always_comb begin
    nxt = ptr;
    if (load) begin
      nxt = load_val;
    end else if (adv) begin
      nxt[IW+1:2] = ptr[IW+1:2] + 1'b1;
    end
  end

  assign nxt_idx = nxt[IW+1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= nxt;
  end

  // R2 / R3: index steps by one word and wraps at MEM_DEPTH
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (ptr[IW+1:2] == IW'($past(ptr[IW+1:2]) + 1'b1)));

  // R2 / R3: bits outside the word index survive a step
  a_r2_keep_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> ((ptr[PW-1:IW+2] == $past(ptr[PW-1:IW+2])) &&
                        (ptr[1:0] == $past(ptr[1:0]))));
endmodule

// File: rtl/ind_sram.sv
module ind_sram #(
  parameter int MEM_DEPTH = 64,
  parameter int DW        = 32,
  localparam int IW       = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ind_shr.sv
module ind_shr
  import ind_pkg::*;
#(
  parameter int SHR_DEPTH = 16,
  localparam int SIW      = $clog2(SHR_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          dat_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] dat_q
);
  shr_cmd_e               cmd;
  logic [1:0]             cnt;
  logic [SHR_OFF_W-1:0]   off;
  logic                   in_range;
  logic [SIW-1:0]         idx;
  logic [DW-1:0]          mask;
  logic                   do_wr;
  logic                   do_rd;
  logic [SHR_DEPTH*DW-1:0] ent_flat;

  assign cmd      = shr_cmd_e'(wdata[SHR_CMD_LSB +: 2]);
  assign cnt      = wdata[SHR_CNT_LSB +: 2];
  assign off      = wdata[SHR_OFF_W-1:0];
  assign in_range = (off[SHR_OFF_W-1:SIW+2] == '0);
  assign idx      = off[SIW+1:2];
  assign mask     = byte_mask(cnt);
  assign do_wr    = ctl_we && (cmd == SHR_WR) && in_range;
  assign do_rd    = ctl_we && (cmd == SHR_RD);

  for (genvar e = 0; e < SHR_DEPTH; e++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (do_wr && (idx == SIW'(e))) begin
        q <= (q & ~mask) | (dat_q & mask);
      end
    end
    assign ent_flat[e*DW +: DW] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dat_q <= '0;
    end else begin
      if (ctl_we) ctl_q <= wdata;
      if (dat_we) begin
        dat_q <= wdata;
      end else if (do_rd) begin
        dat_q <= in_range ? (ent_flat[idx*DW +: DW] & mask) : '0;
      end
    end
  end

  // R9: no-op commands leave file and data word alone
  a_r9_nop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (cmd != SHR_RD) && (cmd != SHR_WR)) |=>
      ($stable(ent_flat) && $stable(dat_q)));

  // R7: single-byte read clears the upper bytes of the data word
  a_r7_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (cmd == SHR_RD) && (cnt == 2'd0)) |=> (dat_q[DW-1:8] == '0));
endmodule

// File: rtl/ind_mem_port.sv
module ind_mem_port
  import ind_pkg::*;
#(
  parameter int MEM_DEPTH = 64,
  parameter int SHR_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [REG_AW-1:0] host_req_addr,
  input  logic [DW-1:0]     host_req_wdata,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [DW-1:0]     host_rsp_rdata
);
  localparam int IW = $clog2(MEM_DEPTH);

  logic          acc, acc_wr, acc_rd;
  logic          is_rdd, rsp_block;
  logic          wr_ptr_ld, rd_ptr_ld, wr_dat_fire, rd_dat_fire;
  logic [DW-1:0] wr_ptr, rd_ptr;
  logic [IW-1:0] wr_nxt_idx, rd_nxt_idx;
  logic [DW-1:0] sram_q;
  logic          q_valid;
  logic [DW-1:0] shr_ctl, shr_dat;
  logic [DW-1:0] rd_mux;

  assign is_rdd    = (host_req_addr == OFF_RD_DATA);
  assign rsp_block = host_rsp_valid && !host_rsp_ready;
  assign host_req_ready = !rsp_block && !(!host_req_write && is_rdd && !q_valid);

  assign acc    = host_req_valid && host_req_ready;
  assign acc_wr = acc && host_req_write;
  assign acc_rd = acc && !host_req_write;

  assign wr_ptr_ld   = acc_wr && (host_req_addr == OFF_WR_ADDR);
  assign rd_ptr_ld   = acc_wr && (host_req_addr == OFF_RD_ADDR);
  assign wr_dat_fire = acc_wr && (host_req_addr == OFF_WR_DATA);
  assign rd_dat_fire = acc_rd && is_rdd;

  ind_ptr #(.MEM_DEPTH(MEM_DEPTH), .PW(DW)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .load(wr_ptr_ld), .load_val(host_req_wdata),
    .adv(wr_dat_fire), .ptr(wr_ptr), .nxt_idx(wr_nxt_idx)
  );

  ind_ptr #(.MEM_DEPTH(MEM_DEPTH), .PW(DW)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .load(rd_ptr_ld), .load_val(host_req_wdata),
    .adv(rd_dat_fire), .ptr(rd_ptr), .nxt_idx(rd_nxt_idx)
  );

  // read port fetches the next read index every cycle
  ind_sram #(.MEM_DEPTH(MEM_DEPTH), .DW(DW)) u_sram (
    .clk(clk), .we(wr_dat_fire), .waddr(wr_ptr[IW+1:2]), .wdata(host_req_wdata),
    .raddr(rd_nxt_idx), .rdata(sram_q)
  );

  // prefetched word is stale when the same edge writes its location
  always_ff @(posedge clk) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= !(wr_dat_fire && (wr_ptr[IW+1:2] == rd_nxt_idx));
  end

  ind_shr #(.SHR_DEPTH(SHR_DEPTH)) u_shr (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(acc_wr && (host_req_addr == OFF_SHR_CTRL)),
    .dat_we(acc_wr && (host_req_addr == OFF_SHR_DATA)),
    .wdata(host_req_wdata), .ctl_q(shr_ctl), .dat_q(shr_dat)
  );

  always_comb begin
    case (host_req_addr)
      OFF_WR_ADDR:  rd_mux = wr_ptr;
      OFF_RD_ADDR:  rd_mux = rd_ptr;
      OFF_RD_DATA:  rd_mux = sram_q;
      OFF_SHR_CTRL: rd_mux = shr_ctl;
      OFF_SHR_DATA: rd_mux = shr_dat;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rsp_valid <= 1'b0;
      host_rsp_rdata <= '0;
    end else if (acc_rd) begin
      host_rsp_valid <= 1'b1;
      host_rsp_rdata <= rd_mux;
    end else if (host_rsp_ready) begin
      host_rsp_valid <= 1'b0;
    end
  end

  // R10: a stalled response keeps its data
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rsp_valid && !host_rsp_ready) |=>
      (host_rsp_valid && $stable(host_rsp_rdata)));
endmodule

// File: tb/sim_ind_mem_port.sv
module sim_ind_mem_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req_valid, host_req_ready, host_req_write;
  logic [7:0]  host_req_addr;
  logic [31:0] host_req_wdata;
  logic        host_rsp_valid, host_rsp_ready;
  logic [31:0] host_rsp_rdata;

  int checks = 0;
  int fails  = 0;
  logic [31:0] ref_mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_mem_port #(.MEM_DEPTH(DEPTH), .SHR_DEPTH(16)) u0 (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_addr(host_req_addr),
    .host_req_wdata(host_req_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_ready(host_rsp_ready),
    .host_rsp_rdata(host_rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req_valid = 1'b1; host_req_write = 1'b1; host_req_addr = a; host_req_wdata = d;
    #1;
    while (!host_req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    host_req_valid = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_req_valid = 1'b1; host_req_write = 1'b0; host_req_addr = a;
    #1;
    while (!host_req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    host_req_valid = 1'b0;
    d = host_rsp_valid ? host_rsp_rdata : 32'hBAD0_BAD0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rsp_valid after reset", {31'd0, host_rsp_valid}, 32'd0);
    bus_read(8'h00, v); check("R1 write pointer", v, 32'd0);
    bus_read(8'h04, v); check("R1 read pointer", v, 32'd0);
    bus_read(8'h10, v); check("R1 shared ctrl", v, 32'd0);
    bus_read(8'h14, v); check("R1 shared data", v, 32'd0);
  endtask

  task automatic t_burst();
    logic [31:0] v;
    bus_write(8'h00, 32'h0000_0100);
    for (int i = 0; i < 16; i++) begin
      ref_mem[i] = 32'hC0DE_0000 + i * 32'h0101_0101;
      bus_write(8'h08, ref_mem[i]);
    end
    bus_read(8'h00, v); check("R2 write pointer after burst", v, 32'h0000_0140);
    bus_write(8'h04, 32'h0000_0100);
    bus_read(8'h04, v); check("R4 read pointer load", v, 32'h0000_0100);
    // back-to-back reads of the read-data register
    for (int i = 0; i <= 16; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R3 burst read valid", {31'd0, host_rsp_valid}, 32'd1);
        check("R3 burst read data", host_rsp_rdata, ref_mem[i-1]);
      end
      if (i < 16) begin
        host_req_valid = 1'b1; host_req_write = 1'b0; host_req_addr = 8'h0C;
        #1;
        check("R5 no stall on streamed read", {31'd0, host_req_ready}, 32'd1);
      end else begin
        host_req_valid = 1'b0;
      end
    end
    bus_read(8'h04, v); check("R3 read pointer after burst", v, 32'h0000_0140);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    bus_write(8'h00, 32'h1234_00FD);
    ref_mem[63] = 32'hAAAA_0063; bus_write(8'h08, ref_mem[63]);
    ref_mem[0]  = 32'hBBBB_0000; bus_write(8'h08, ref_mem[0]);
    bus_read(8'h00, v); check("R2 wrap keeps upper and low bits", v, 32'h1234_0005);
    bus_write(8'h04, 32'h0000_00FC);
    bus_read(8'h0C, v); check("R3 read last word", v, ref_mem[63]);
    bus_read(8'h0C, v); check("R3 read after wrap", v, ref_mem[0]);
    bus_read(8'h04, v); check("R3 read pointer wraps", v, 32'h0000_0004);
  endtask

  task automatic t_coherent();
    logic [31:0] v;
    bus_write(8'h04, 32'h0000_0008);
    bus_write(8'h00, 32'h0000_0008);
    ref_mem[2] = 32'h5EED_F00D;
    bus_write(8'h08, ref_mem[2]);
    bus_read(8'h0C, v); check("R6 read sees fresh write", v, ref_mem[2]);
    bus_read(8'h0C, v); check("R6 following word intact", v, ref_mem[3]);
  endtask

  task automatic t_stall();
    logic [31:0] v, held;
    @(negedge clk);
    host_rsp_ready = 1'b0;
    host_req_valid = 1'b1; host_req_write = 1'b0; host_req_addr = 8'h04;
    #1;
    check("R10 first request accepted", {31'd0, host_req_ready}, 32'd1);
    @(negedge clk);
    held = host_rsp_rdata;
    check("R10 response raised", {31'd0, host_rsp_valid}, 32'd1);
    check("R10 response data", held, 32'h0000_0010);
    host_req_write = 1'b1; host_req_addr = 8'h00; host_req_wdata = 32'h0000_0200;
    #1;
    check("R10 request held off", {31'd0, host_req_ready}, 32'd0);
    @(negedge clk);
    check("R10 response still valid", {31'd0, host_rsp_valid}, 32'd1);
    check("R10 response data held", host_rsp_rdata, held);
    check("R10 still held off", {31'd0, host_req_ready}, 32'd0);
    host_rsp_ready = 1'b1;
    #1;
    check("R10 ready after take", {31'd0, host_req_ready}, 32'd1);
    @(negedge clk);
    host_req_valid = 1'b0;
    check("R10 single response", {31'd0, host_rsp_valid}, 32'd0);
    bus_read(8'h00, v); check("R10 held write applied", v, 32'h0000_0200);
  endtask

  task automatic t_shared();
    logic [31:0] v;
    bus_write(8'h14, 32'hA5A5_1234);
    bus_write(8'h10, 32'h3300_000C);
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_write(8'h10, 32'h3000_000C);
    bus_write(8'h10, 32'h2300_000C);
    bus_read(8'h14, v); check("R8 byte-limited write merge", v, 32'hA5A5_12FF);
    bus_read(8'h10, v); check("R7 control readback", v, 32'h2300_000C);
    bus_write(8'h10, 32'h2100_000C);
    bus_read(8'h14, v); check("R7 two-byte read mask", v, 32'h0000_12FF);
    bus_write(8'h10, 32'h0300_000C);
    bus_read(8'h14, v); check("R9 command 0 ignored", v, 32'h0000_12FF);
    bus_write(8'h10, 32'h1300_0000);
    bus_read(8'h14, v); check("R9 command 1 ignored", v, 32'h0000_12FF);
    bus_write(8'h14, 32'h1111_1111);
    bus_write(8'h10, 32'h3300_0000);
    bus_write(8'h14, 32'h2222_2222);
    bus_write(8'h10, 32'h3300_0040);
    bus_write(8'h10, 32'h2300_0000);
    bus_read(8'h14, v); check("R9 out-of-range write dropped", v, 32'h1111_1111);
    bus_write(8'h10, 32'h2300_0100);
    bus_read(8'h14, v); check("R9 out-of-range read gives 0", v, 32'h0000_0000);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_write(8'h3C, 32'hDEAD_BEEF);
    bus_read(8'h3C, v); check("R11 unmapped reads 0", v, 32'd0);
    bus_read(8'h08, v); check("R11 write-data reads 0", v, 32'd0);
    bus_read(8'h00, v); check("R11 write pointer untouched", v, 32'h0000_0200);
    bus_read(8'h04, v); check("R11 read pointer untouched", v, 32'h0000_0010);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_req_valid = 1'b0; host_req_write = 1'b0;
    host_req_addr = '0; host_req_wdata = '0;
    host_rsp_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_burst();
    t_wrap();
    t_coherent();
    t_stall();
    t_shared();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule